// File: doc/BRIEF.md
# Word-Clock Ratio Supervisor

This block supervises start-up and shutdown of a serial audio datapath. It runs on the master clock and watches the word clock, which arrives as an asynchronous input. After reset it holds the datapath in power-down. It counts master clocks per word-clock period and sorts each count into one of three supported ratios: 256, 384 or 512.

Once two successive periods give the same valid ratio, it releases the datapath. It then drives the run enable high, drops the datapath reset, and reports the ratio it locked to. It returns to power-down in three cases: the word clock stops, a period falls outside every supported ratio, or the ratio changes. Analog power control and supply sensing are handled elsewhere.

Top module: `wclk_ratio_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, run_en is 0, dp_rst is 1 and ratio_code is 2'b11. A reset asserted during normal operation returns the block to this state.
- R2: A period is the number of master clocks between two successive word-clock rising edges. It is classified as 2'b00 for 256, 2'b01 for 384 and 2'b10 for 512, each within plus or minus 2 (the parameter TOL). Any other count is 2'b11, meaning invalid.
- R3: Normal operation starts only on a word-clock rising edge whose period has the same valid code as the period just before it. The first edge after reset or after clock loss never yields a valid period. Periods that alternate between two ratios never start normal operation.
- R4: A period classified as 2'b11 keeps the block in power-down, or returns it there.
- R5: While run_en is 1, ratio_code holds the locked ratio and is never 2'b11.
- R6: In normal operation run_en is 1 and dp_rst is 0. In power-down run_en is 0, dp_rst is 1 and ratio_code is 2'b11.
- R7: If no word-clock rising edge arrives for 1024 master clocks (parameter LOSS_LIMIT), the block returns to power-down. It stays in normal operation for at least 1000 master clocks after the last edge.
- R8: While running, a valid period whose code differs from the locked one returns the block to power-down. Relocking then needs two successive equal valid periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, asynchronous to clk |
| ratio_code | output | 2 | Locked ratio: 00=256, 01=384, 10=512, 11=none |
| run_en | output | 1 | High in normal operation |
| dp_rst | output | 1 | Datapath reset, high in power-down |

## Verification
The bench uses the default parameters: a two-flop synchronizer, a tolerance of 2 and a 1024-cycle loss limit. With these values, one stimulus run covers all three ratios, off-ratio periods at the edges of the tolerance window (254 and 513 accepted, 259 and 515 rejected), and a watchdog expiry. A scoreboard queue holds the expected sequence of output transitions. It catches missing, extra and out-of-order transitions during ratio changes, alternating periods and resets in the middle of a run.

// File: rtl/wsup_pkg.sv
package wsup_pkg;
  typedef enum logic [1:0] {
    RATIO_256 = 2'b00,
    RATIO_384 = 2'b01,
    RATIO_512 = 2'b10,
    RATIO_BAD = 2'b11
  } ratio_e;

  typedef enum logic {
    SEQ_DOWN = 1'b0,
    SEQ_UP   = 1'b1
  } seq_e;
endpackage

// File: rtl/wsup_edge_sync.sv
module wsup_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/wsup_period_meter.sv
module wsup_period_meter #(
  parameter int LOSS_LIMIT = 1024,
  parameter int CNT_W      = $clog2(LOSS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] count,
  output logic             lost
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(LOSS_LIMIT);

  // Reset to saturation so the first edge after reset gives no valid period
  always_ff @(posedge clk) begin
    if (rst)             count <= SAT;
    else if (rise)       count <= CNT_W'(1);
    else if (count != SAT) count <= count + CNT_W'(1);
  end

  assign lost = (count == SAT);

  // R7: the loss counter never runs past its limit
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= SAT);
endmodule

// File: rtl/wsup_classify.sv
module wsup_classify
  import wsup_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int R_LO  = 256,
  parameter int R_MID = 384,
  parameter int R_HI  = 512,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] count,
  output ratio_e           code
);
  localparam int NUM = 3;
  localparam int RATIOS [NUM] = '{R_LO, R_MID, R_HI};

  logic [NUM-1:0] hit;

  for (genvar i = 0; i < NUM; i++) begin : g_win
    always_comb begin
      int diff;
      diff   = int'(count) - RATIOS[i];
      hit[i] = (diff <= TOL) && (diff >= -TOL);
    end
  end

  always_comb begin
    if (hit[0])      code = RATIO_256;
    else if (hit[1]) code = RATIO_384;
    else if (hit[2]) code = RATIO_512;
    else             code = RATIO_BAD;
  end
endmodule

// File: rtl/wclk_ratio_supervisor.sv
module wclk_ratio_supervisor
  import wsup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_LIMIT  = 1024,
  parameter int TOL         = 2,
  parameter int R_LO        = 256,
  parameter int R_MID       = 384,
  parameter int R_HI        = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wclk_in,
  output logic [1:0] ratio_code,
  output logic       run_en,
  output logic       dp_rst
);
  localparam int CNT_W = $clog2(LOSS_LIMIT + 1);

  logic             rise;
  logic             lost;
  logic [CNT_W-1:0] count;
  ratio_e           code_now;
  ratio_e           prev_code;
  ratio_e           locked;
  seq_e             state;

  wsup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(wclk_in), .rise(rise)
  );

  wsup_period_meter #(.LOSS_LIMIT(LOSS_LIMIT), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .rise(rise), .count(count), .lost(lost)
  );

  wsup_classify #(
    .CNT_W(CNT_W), .R_LO(R_LO), .R_MID(R_MID), .R_HI(R_HI), .TOL(TOL)
  ) u_class (
    .count(count), .code(code_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_DOWN;
      prev_code <= RATIO_BAD;
      locked    <= RATIO_BAD;
      run_en    <= 1'b0;
      dp_rst    <= 1'b1;
    end else if (rise) begin
      prev_code <= code_now;
      if (state == SEQ_DOWN) begin
        if (code_now != RATIO_BAD && code_now == prev_code) begin
          state  <= SEQ_UP;
          locked <= code_now;
          run_en <= 1'b1;
          dp_rst <= 1'b0;
        end
      end else if (code_now != locked) begin
        state  <= SEQ_DOWN;
        locked <= RATIO_BAD;
        run_en <= 1'b0;
        dp_rst <= 1'b1;
      end
    end else if (lost) begin
      state     <= SEQ_DOWN;
      prev_code <= RATIO_BAD;
      locked    <= RATIO_BAD;
      run_en    <= 1'b0;
      dp_rst    <= 1'b1;
    end
  end

  assign ratio_code = locked;

  // R1: reset forces power-down outputs
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!run_en && dp_rst && ratio_code == 2'b11));

  // R5: a running datapath always has a real ratio
  a_r5_run_code_valid: assert property (@(posedge clk) disable iff (rst)
    run_en |-> ratio_code != 2'b11);

  // R3: normal operation begins only on a word-clock edge
  a_r3_up_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> $past(rise));

  // R4: an invalid period leaves the datapath stopped
  a_r4_bad_drops: assert property (@(posedge clk) disable iff (rst)
    (rise && code_now == RATIO_BAD) |=> !run_en);

  // R7: watchdog expiry stops the datapath
  a_r7_loss_drops: assert property (@(posedge clk) disable iff (rst)
    (lost && !rise) |=> (!run_en && dp_rst));
endmodule

// File: tb/wclk_ratio_supervisor_test.sv
module wclk_ratio_supervisor_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wclk = 1'b0;
  logic [1:0] ratio_code;
  logic       run_en;
  logic       dp_rst;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] last_seen;

  always #10 clk = ~clk;

  wclk_ratio_supervisor uut (
    .clk(clk), .rst(rst), .wclk_in(wclk),
    .ratio_code(ratio_code), .run_en(run_en), .dp_rst(dp_rst)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic word_clocks(int period, int n);
    repeat (n) begin
      wclk = 1'b1;
      repeat (period / 2) @(negedge clk);
      wclk = 1'b0;
      repeat (period - period / 2) @(negedge clk);
    end
  endtask

  task automatic expect_state(bit run, logic [1:0] code, string req);
    check(run_en === run, req, "run_en", int'(run_en), int'(run));
    check(dp_rst === !run, req, "dp_rst", int'(dp_rst), int'(!run));
    check(ratio_code === code, req, "ratio_code", int'(ratio_code), int'(code));
  endtask

  // Monitor: every output change must match the next queued expectation
  always @(negedge clk) begin
    if (mon_on) begin
      logic [2:0] cur;
      cur = {run_en, ratio_code};
      if (cur !== last_seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected transition", int'(cur), int'(last_seen));
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cur === e, t, "transition", int'(cur), int'(e));
        end
        last_seen = cur;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(5);
    expect_state(1'b0, 2'b11, "R1 reset");
    rst = 1'b0;
    last_seen = 3'b011;
    mon_on = 1'b1;
    idle(3);
    expect_state(1'b0, 2'b11, "R1 after reset");

    // R3: two edges give one usable period only
    word_clocks(256, 2);
    expect_state(1'b0, 2'b11, "R3 single period");
    push(3'b100, "R3 lock 256");
    word_clocks(256, 4);
    expect_state(1'b1, 2'b00, "R2 R6 run at 256");

    // R7: watchdog on a stopped word clock
    idle(1010 - 256);
    expect_state(1'b1, 2'b00, "R7 before limit");
    push(3'b011, "R7 loss");
    idle(40);
    expect_state(1'b0, 2'b11, "R7 after limit");

    push(3'b101, "R2 lock 384");
    word_clocks(384, 4);
    expect_state(1'b1, 2'b01, "R2 R5 run at 384");

    // R8: ratio change drops then relocks; 513 lies inside the 512 window
    push(3'b011, "R8 drop on change");
    push(3'b110, "R8 relock 513");
    word_clocks(513, 4);
    expect_state(1'b1, 2'b10, "R8 R2 run at 512+1");

    // R4: 515 is outside tolerance
    push(3'b011, "R4 drop on 515");
    word_clocks(515, 4);
    expect_state(1'b0, 2'b11, "R4 stays down at 515");
    word_clocks(259, 4);
    expect_state(1'b0, 2'b11, "R4 stays down at 259");

    // R3: alternating ratios never lock
    for (int i = 0; i < 3; i++) begin
      word_clocks(256, 1);
      word_clocks(384, 1);
    end
    expect_state(1'b0, 2'b11, "R3 alternating");

    push(3'b100, "R2 lock 254");
    word_clocks(254, 4);
    expect_state(1'b1, 2'b00, "R2 run at 256-2");

    push(3'b011, "R1 reset in run");
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(3);
    expect_state(1'b0, 2'b11, "R1 reset in run");

    idle(5);
    check(exp_q.size() == 0, "R6", "pending transitions", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule